// File: doc/BRIEF.md
# Banked ROM Pager with Periodic Interrupt

This block sits beside an 8-bit processor with a 64 KB address space and turns each bus cycle into chip selects and memory addresses. The low part of the space reaches a RAM, a 4 KB window holds peripheral registers, a 16 KB window shows one selectable bank of a large program ROM, and the upper 32 KB always shows the last 32 KB of that ROM, so the reset vectors at 0xFFFE/0xFFFF are the final two ROM bytes whatever bank is selected.

Firmware picks the bank by writing the bank register at 0x3FFC. A firmware ROM self-test first reads the fixed upper half, then steps the bank register through each lower bank and reads it through the paged window. The block also raises a periodic interrupt from a free-running divider of the bus clock (default 2000 cycles, 1 kHz from a 2 MHz bus). The request stays up until firmware writes the acknowledge register; the divider never stops or restarts.

Top module: `bank_pager`

## Requirements
- R1: After reset the bank register reads 0 and the interrupt output is low.
- R2: A valid cycle to 0x0000–0x2FFF asserts only `ram_cs`, with `ram_addr` equal to CPU address bits 13:0.
- R3: A valid cycle to 0x3000–0x3FFF asserts only `periph_cs`, except at the bank register (0x3FFC) and the acknowledge register (0x3FF7), which assert no chip select and are answered by the block.
- R4: A valid write to 0x3FFC loads the low BANK_W data bits into the bank register from the next cycle; a read of 0x3FFC returns the bank zero-extended on `rdata` with `rdata_en` high.
- R5: A valid cycle to 0x4000–0x7FFF asserts only `rom_cs`, with `rom_addr` = {bank, CPU address bits 13:0}.
- R6: A valid cycle to 0x8000–0xFFFF asserts only `rom_cs`, with `rom_addr` = {all ones in the top BANK_W-1 bits, CPU address bits 14:0}, independent of the bank; 0xFFFE and 0xFFFF map to the last two ROM bytes.
- R7: The interrupt output rises exactly once every TICKS clock cycles.
- R8: Once high, the interrupt stays high until a valid write to 0x3FF7, after which it is low from the next cycle.
- R9: Acknowledge writes do not shift the interrupt period; the next rise stays on the TICKS grid.
- R10: A cycle with `cpu_valid` low, or a read of 0x3FFC, leaves the bank register unchanged.
- R11: At most one chip select is active at a time, and with `cpu_valid` low no chip select and no `rdata_en` are asserted.
- R12: An acknowledge write sampled on the same edge that ends a period leaves the interrupt high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Bus cycle in progress |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ram_cs | output | 1 | RAM select |
| ram_addr | output | 14 | RAM address |
| rom_cs | output | 1 | ROM select |
| rom_addr | output | BANK_W+14 | ROM byte address |
| periph_cs | output | 1 | Peripheral register window select |
| rdata_en | output | 1 | Block drives `rdata` on this read |
| rdata | output | 8 | Read data of the block's own registers |
| irq | output | 1 | Periodic interrupt request, active high |

## Verification
Chip selects, `ram_addr`, `rom_addr` and `rdata` are combinational, so the bench drives a cycle just after a falling edge and samples a nanosecond later, before the next rising edge. A bank or acknowledge write takes effect on the rising edge that samples it, so its result is checked at the following falling edge. Interrupt rises are located by a cycle counter read at falling edges; the interval between two rises must equal TICKS, and the collision case is set up by placing the acknowledge on the cycle that is TICKS-1 edges after a detected rise.

// File: rtl/pager_pkg.sv
package pager_pkg;

  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;
  localparam int WIN_AW = 14;
  localparam int FIX_AW = 15;

  localparam logic [CPU_AW-1:0] DEF_BANK_ADDR = 16'h3FFC;
  localparam logic [CPU_AW-1:0] DEF_ACK_ADDR  = 16'h3FF7;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAM,
    RG_IO,
    RG_BANK,
    RG_ACK,
    RG_PAGED,
    RG_FIXED
  } region_e;

endpackage

// File: rtl/pager_rst_sync.sv
module pager_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pager_decode.sv
module pager_decode
  import pager_pkg::*;
#(
  parameter logic [CPU_AW-1:0] BANK_ADDR = DEF_BANK_ADDR,
  parameter logic [CPU_AW-1:0] ACK_ADDR  = DEF_ACK_ADDR
) (
  input  logic              valid,
  input  logic [CPU_AW-1:0] addr,
  output region_e           region
);

  always_comb begin
    if (!valid)                  region = RG_NONE;
    else if (addr[15])           region = RG_FIXED;
    else if (addr[14])           region = RG_PAGED;
    else if (addr == BANK_ADDR)  region = RG_BANK;
    else if (addr == ACK_ADDR)   region = RG_ACK;
    else if (addr[13:12] == 2'b11) region = RG_IO;
    else                         region = RG_RAM;
  end

endmodule

// File: rtl/pager_bank_reg.sv
module pager_bank_reg #(
  parameter int BANK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank
);

  logic [BANK_W-1:0] bank_d, bank_q;

  always_comb begin
    bank_d = bank_q;
    if (load_en) bank_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (load_en) bank_q <= bank_d;
  end

  assign bank = bank_q;

endmodule

// File: rtl/pager_irq_timer.sv
module pager_irq_timer #(
  parameter int TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic irq
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_d, cnt_q;
  logic          irq_d, irq_q;
  logic          period_end;

  always_comb begin
    period_end = (cnt_q == LAST);
    cnt_d      = period_end ? '0 : cnt_q + 1'b1;
    if (period_end)  irq_d = 1'b1;
    else if (ack)    irq_d = 1'b0;
    else             irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/bank_pager.sv
module bank_pager
  import pager_pkg::*;
#(
  parameter int                BANK_W    = 6,
  parameter int                TICKS     = 2000,
  parameter logic [15:0]       BANK_ADDR = DEF_BANK_ADDR,
  parameter logic [15:0]       ACK_ADDR  = DEF_ACK_ADDR,
  localparam int               ROM_AW    = BANK_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              ram_cs,
  output logic [13:0]       ram_addr,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              periph_cs,
  output logic              rdata_en,
  output logic [7:0]        rdata,
  output logic              irq
);

  localparam int TOP_W = BANK_W - 1;

  logic              rst_n_s;
  region_e           region;
  logic [BANK_W-1:0] bank_q;
  logic              bank_wr;
  logic              ack_wr;
  logic              unused_wdata;

  pager_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pager_decode #(.BANK_ADDR(BANK_ADDR), .ACK_ADDR(ACK_ADDR)) u_dec (
    .valid  (cpu_valid),
    .addr   (cpu_addr),
    .region (region)
  );

  assign bank_wr = (region == RG_BANK) && cpu_we;
  assign ack_wr  = (region == RG_ACK)  && cpu_we;

  pager_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_en  (bank_wr),
    .load_val (cpu_wdata[BANK_W-1:0]),
    .bank     (bank_q)
  );

  pager_irq_timer #(.TICKS(TICKS)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ack   (ack_wr),
    .irq   (irq)
  );

  generate
    if (BANK_W < 8) begin : g_pad
      assign unused_wdata = ^cpu_wdata[7:BANK_W];
    end else begin : g_nopad
      assign unused_wdata = 1'b0;
    end
  endgenerate

  assign ram_cs    = (region == RG_RAM);
  assign periph_cs = (region == RG_IO);
  assign rom_cs    = (region == RG_PAGED) || (region == RG_FIXED);
  assign ram_addr  = cpu_addr[13:0];

  always_comb begin
    if (region == RG_FIXED)
      rom_addr = {{TOP_W{1'b1}}, cpu_addr[FIX_AW-1:0]};
    else
      rom_addr = {bank_q, cpu_addr[WIN_AW-1:0]};
  end

  always_comb begin
    rdata    = '0;
    rdata_en = 1'b0;
    if (!cpu_we) begin
      case (region)
        RG_BANK: begin
          rdata[BANK_W-1:0] = bank_q;
          rdata_en          = 1'b1;
        end
        RG_ACK: begin
          rdata[0] = irq;
          rdata_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bank_pager_chk.sv
module bank_pager_chk #(
  parameter int          BANK_W    = 6,
  parameter int          TICKS     = 2000,
  parameter logic [15:0] BANK_ADDR = 16'h3FFC,
  parameter logic [15:0] ACK_ADDR  = 16'h3FF7,
  localparam int         ROM_AW    = BANK_W + 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              ram_cs,
  input logic              rom_cs,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              periph_cs,
  input logic              rdata_en,
  input logic              irq,
  input logic [BANK_W-1:0] bank
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] ref_cnt;
  logic          wr_bank, wr_ack;

  assign wr_bank = cpu_valid && cpu_we && (cpu_addr == BANK_ADDR);
  assign wr_ack  = cpu_valid && cpu_we && (cpu_addr == ACK_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ref_cnt <= '0;
    else if (ref_cnt == LAST)  ref_cnt <= '0;
    else                       ref_cnt <= ref_cnt + 1'b1;
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, rom_cs, periph_cs}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> !(ram_cs || rom_cs || periph_cs || rdata_en));

  // R4
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank |=> (bank == $past(cpu_wdata[BANK_W-1:0])));

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bank |=> $stable(bank));

  // R6
  fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[15]) |->
      (rom_cs && (&rom_addr[ROM_AW-1:15]) && (rom_addr[14:0] == cpu_addr[14:0])));

  // R5
  paged_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && (cpu_addr[15:14] == 2'b01)) |->
      (rom_cs && (rom_addr == {bank, cpu_addr[13:0]})));

  // R7
  irq_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ref_cnt == '0));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ack) |=> irq);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && (ref_cnt != LAST)) |=> !irq);

  // R12
  ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && (ref_cnt == LAST)) |=> irq);

endmodule

bind bank_pager bank_pager_chk #(
  .BANK_W    (BANK_W),
  .TICKS     (TICKS),
  .BANK_ADDR (BANK_ADDR),
  .ACK_ADDR  (ACK_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cpu_valid (cpu_valid),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .ram_cs    (ram_cs),
  .rom_cs    (rom_cs),
  .rom_addr  (rom_addr),
  .periph_cs (periph_cs),
  .rdata_en  (rdata_en),
  .irq       (irq),
  .bank      (bank_q)
);

// File: tb/bank_pager_test.sv
module bank_pager_test;

  localparam int BW  = 6;
  localparam int TK  = 40;
  localparam int RAW = BW + 14;
  localparam logic [15:0] A_BANK = 16'h3FFC;
  localparam logic [15:0] A_ACK  = 16'h3FF7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cpu_valid, cpu_we;
  logic [15:0]    cpu_addr;
  logic [7:0]     cpu_wdata;
  logic           ram_cs, rom_cs, periph_cs, rdata_en, irq;
  logic [13:0]    ram_addr;
  logic [RAW-1:0] rom_addr;
  logic [7:0]     rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_pager #(.BANK_W(BW), .TICKS(TK)) uut (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_addr, .cpu_wdata,
    .ram_cs, .ram_addr, .rom_cs, .rom_addr, .periph_cs,
    .rdata_en, .rdata, .irq
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic we,
                       input logic [15:0] a, input logic [7:0] d);
    cpu_valid = v; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); drive(1'b1, 1'b1, a, d);
    @(negedge clk); drive(1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk); drive(1'b1, 1'b0, a, 8'h00); #1;
  endtask

  task automatic sels(input string req, input logic [3:0] exp);
    chk(req, "selects{ram,rom,io,rden}", {28'h0, ram_cs, rom_cs, periph_cs, rdata_en}, {28'h0, exp});
  endtask

  task automatic wait_rise(output int at);
    at = -1;
    for (int i = 0; i < 4 * TK; i++) begin
      @(negedge clk);
      if (irq === 1'b1) begin at = cyc; break; end
    end
    chk("R7", "irq rise seen", {31'h0, at >= 0}, 32'h1);
  endtask

  task automatic t_reset;
    drive(1'b0, 1'b0, 16'h0, 8'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
    probe(A_BANK);
    chk("R1", "bank after reset", {24'h0, rdata}, 32'h0);
    sels("R3", 4'b0001);
  endtask

  task automatic t_ram;
    probe(16'h0000); sels("R2", 4'b1000);
    chk("R2", "ram_addr 0000", {18'h0, ram_addr}, 32'h0000);
    probe(16'h1234); sels("R2", 4'b1000);
    chk("R2", "ram_addr 1234", {18'h0, ram_addr}, 32'h1234);
    probe(16'h2FFF); sels("R2", 4'b1000);
    chk("R2", "ram_addr 2FFF", {18'h0, ram_addr}, 32'h2FFF);
  endtask

  task automatic t_io;
    probe(16'h3000); sels("R3", 4'b0010);
    probe(16'h3FFB); sels("R3", 4'b0010);
    probe(16'h3FFF); sels("R3", 4'b0010);
    probe(A_ACK);    sels("R3", 4'b0001);
  endtask

  task automatic t_bank;
    wr(A_BANK, 8'h05);
    probe(A_BANK);
    chk("R4", "bank readback", {24'h0, rdata}, 32'h05);
    probe(16'h4123); sels("R5", 4'b0100);
    chk("R5", "paged 4123 bank5", {12'h0, rom_addr}, 32'h14123);
    wr(A_BANK, 8'hFF);
    probe(A_BANK);
    chk("R4", "bank upper bits dropped", {24'h0, rdata}, 32'h3F);
    probe(16'h7FFF);
    chk("R5", "paged 7FFF bank63", {12'h0, rom_addr}, 32'hFFFFF);
    wr(A_BANK, 8'h00);
    probe(16'h4000);
    chk("R5", "paged 4000 bank0", {12'h0, rom_addr}, 32'h00000);
  endtask

  task automatic t_fixed;
    probe(16'hFFFE); sels("R6", 4'b0100);
    chk("R6", "FFFE bank0", {12'h0, rom_addr}, 32'hFFFFE);
    probe(16'h8000);
    chk("R6", "8000 bank0", {12'h0, rom_addr}, 32'hF8000);
    wr(A_BANK, 8'h2A);
    probe(16'hFFFF);
    chk("R6", "FFFF bank42", {12'h0, rom_addr}, 32'hFFFFF);
    probe(16'hC001);
    chk("R6", "C001 bank42", {12'h0, rom_addr}, 32'hFC001);
  endtask

  task automatic t_ignore;
    @(negedge clk); drive(1'b0, 1'b1, A_BANK, 8'h09); #1;
    sels("R11", 4'b0000);
    @(negedge clk); drive(1'b0, 1'b1, 16'h1000, 8'h09); #1;
    sels("R11", 4'b0000);
    @(negedge clk); drive(1'b1, 1'b0, A_BANK, 8'h07);
    @(negedge clk); drive(1'b0, 1'b0, 16'h0, 8'h0);
    probe(A_BANK);
    chk("R10", "bank after ignored cycles", {24'h0, rdata}, 32'h2A);
  endtask

  task automatic t_irq;
    int r1, r2;
    wr(A_ACK, 8'h00);
    wait_rise(r1);
    repeat (5) @(negedge clk);
    chk("R8", "irq held without ack", {31'h0, irq}, 32'h1);
    probe(A_ACK);
    chk("R8", "status read", {24'h0, rdata}, 32'h01);
    drive(1'b1, 1'b1, A_ACK, 8'h00);
    @(negedge clk); drive(1'b0, 1'b0, 16'h0, 8'h0);
    chk("R8", "irq cleared by ack", {31'h0, irq}, 32'h0);
    wait_rise(r2);
    chk("R9", "period across ack", r2 - r1, TK);
    repeat (TK - 1) @(negedge clk);
    drive(1'b1, 1'b1, A_ACK, 8'h00);
    @(negedge clk); drive(1'b0, 1'b0, 16'h0, 8'h0);
    chk("R12", "irq kept on collision", {31'h0, irq}, 32'h1);
    chk("R7", "collision edge on grid", cyc - r2, TK);
    wr(A_ACK, 8'h00);
    chk("R8", "irq cleared after collision", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ram();
    t_io();
    t_bank();
    t_fixed();
    t_ignore();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule